// File: doc/BRIEF.md
# Partitioned Flash Line Buffer Controller

This block keeps four line buffers in front of a slow flash array. Each read request carries a line address, a flag saying whether it is an instruction fetch or a data access, and a flag saying whether it continues a sequential stream. A request that finds its line in a buffer it may use is answered from that buffer one cycle later. A request that misses fetches the line through a simple request/acknowledge fill port, answers with the fetched data and, when allowed, stores the line. For some configurations it then fetches the following line ahead of time.

The buffers can be shared by both access types. They can also be split in one of two fixed ways: two buffers per type, or three buffers for instructions and one for data. In the second split, data lookahead is off. All lines are dropped when the invalidate input is pulsed or while the buffer enable is low. They are also dropped when a non-sequential request is accepted while an emulated wait-state value is non-zero. The wait-state delay itself is not modelled here. Only its effect on buffering is.

Top module: `flash_line_buf`

## Requirements
- R1: While reset is held and right after it, no line is valid, and `busy_o`, `arr_req_o` and `rsp_valid_o` are low.
- R2: An accepted request hits when `buf_en_i` is 1, `ws_emul_i` is 0, and a valid buffer that the request's type may use holds its line. A hit raises `rsp_valid_o` and `rsp_hit_o` one cycle after acceptance, returns the stored data and issues no array request.
- R3: An accepted request that misses holds `arr_req_o` high with `arr_line_o` equal to its line until `arr_ack_i`. The cycle after the acknowledge, it returns `arr_data_i` with `rsp_valid_o` high and `rsp_hit_o` low. The line is stored if the request was cacheable when it was accepted (enable 1, wait state 0).
- R4: `part_mode_i` selects which buffers each type may use for hits and fills. 00 and 11: all four for both types. 01: buffers 0–1 for instructions, 2–3 for data. 10: buffers 0–2 for instructions, buffer 3 for data.
- R5: A fill goes to the lowest-numbered invalid buffer the type may use; failing that, to the least recently used one. After reset the recency order is buffer 0 newest to buffer 3 oldest. Hits and fills make a buffer the newest.
- R6: After a stored demand fill, if lookahead is enabled for the type, the block fetches line+1 (modulo the line space) into the same partition, unless that line is already there. Data lookahead needs `pf_data_en_i` and is always off in mode 10. Instruction lookahead needs `pf_instr_en_i`.
- R7: A high `inv_i` clears every line at the next clock edge; this takes priority over a fill finishing in the same cycle.
- R8: While `buf_en_i` is low, nothing hits and nothing is stored, and all lines are cleared, so re-enabling starts empty. Misses are still served from the array.
- R9: While `ws_emul_i` is non-zero, hits are ignored, nothing is stored and no lookahead starts. Accepting a request with `req_seq_i` low under a non-zero `ws_emul_i` clears all lines.
- R10: An invalidation during a demand fill still lets the demand be answered, but the line is not stored and no lookahead follows. An invalidation during a lookahead fill abandons it, and `arr_req_o` falls on the next cycle.
- R11: A request is taken only in a cycle where `busy_o` is low. `busy_o` stays high from a miss until its fill, and any lookahead fill, ends. Requests offered while busy are dropped and leave no trace.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Read request present |
| req_line_i | input | LINE_AW | Requested line address |
| req_instr_i | input | 1 | 1 = instruction fetch, 0 = data access |
| req_seq_i | input | 1 | 1 = sequential continuation |
| buf_en_i | input | 1 | Buffer enable; low disables and clears |
| part_mode_i | input | 2 | Partition select (see R4) |
| pf_instr_en_i | input | 1 | Instruction lookahead enable |
| pf_data_en_i | input | 1 | Data lookahead enable |
| ws_emul_i | input | WS_W | Emulated wait-state value |
| inv_i | input | 1 | Invalidate all lines |
| arr_req_o | output | 1 | Array fill request |
| arr_line_o | output | LINE_AW | Line being fetched |
| arr_ack_i | input | 1 | Array fill done, data valid |
| arr_data_i | input | DATA_W | Array line data |
| busy_o | output | 1 | Fill in progress; requests not taken |
| rsp_valid_o | output | 1 | Response valid |
| rsp_hit_o | output | 1 | Response came from a buffer |
| rsp_data_o | output | DATA_W | Response data |

## Verification
The assertions assume that `part_mode_i` changes only after the lines have been cleared by a low `buf_en_i`. They also assume that `arr_ack_i` is raised only while `arr_req_o` is high and that configuration stays fixed during a lookahead fill. Without the first, a line stored under one partition could match twice under another. The stimulus meets these by routing every mode change through a three-step sequence: enable low, then mode change, then enable high. Its array model acknowledges only a pending request, after a fixed latency, and drops its count when the request falls.

// File: rtl/flb_pkg.sv
package flb_pkg;
  localparam int unsigned NBUF  = 4;
  localparam int unsigned IDX_W = $clog2(NBUF);

  typedef enum logic [1:0] {
    PM_SHARED     = 2'b00,
    PM_SPLIT_2I2D = 2'b01,
    PM_SPLIT_3I1D = 2'b10,
    PM_SHARED_ALT = 2'b11
  } part_mode_e;

  typedef enum logic [1:0] {ST_IDLE, ST_FILL, ST_PREF} fsm_e;

  function automatic logic [NBUF-1:0] allow_mask(input logic [1:0] mode, input logic instr);
    case (mode)
      PM_SPLIT_2I2D: allow_mask = instr ? NBUF'(4'b0011) : NBUF'(4'b1100);
      PM_SPLIT_3I1D: allow_mask = instr ? NBUF'(4'b0111) : NBUF'(4'b1000);
      default:       allow_mask = '1;
    endcase
  endfunction
endpackage

// File: rtl/flb_lookup.sv
module flb_lookup import flb_pkg::*; #(
  parameter int unsigned LINE_AW = 12
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic [LINE_AW-1:0]                line_i,
  input  logic [LINE_AW-1:0]                pf_line_i,
  input  logic [NBUF-1:0]                   mask_i,
  input  logic [NBUF-1:0]                   valid_i,
  input  logic [NBUF-1:0][LINE_AW-1:0]      tags_i,
  input  logic [NBUF-1:0][IDX_W-1:0]        rank_i,
  output logic                              hit_o,
  output logic [IDX_W-1:0]                  hit_idx_o,
  output logic                              pf_hit_o,
  output logic [IDX_W-1:0]                  victim_o
);
  logic [NBUF-1:0] match, pf_match;

  for (genvar g = 0; g < NBUF; g++) begin : g_cmp
    assign match[g]    = valid_i[g] & mask_i[g] & (tags_i[g] == line_i);
    assign pf_match[g] = valid_i[g] & mask_i[g] & (tags_i[g] == pf_line_i);
  end

  assign hit_o    = |match;
  assign pf_hit_o = |pf_match;

  always_comb begin
    hit_idx_o = '0;
    for (int i = 0; i < NBUF; i++)
      if (match[i]) hit_idx_o = IDX_W'(i);
  end

  // invalid slot first (lowest index), else oldest rank within the mask
  always_comb begin
    logic             got_inv, got_any;
    logic [IDX_W-1:0] inv_idx, lru_idx, best;
    got_inv = 1'b0; got_any = 1'b0;
    inv_idx = '0;   lru_idx = '0;   best = '0;
    for (int i = 0; i < NBUF; i++) begin
      if (mask_i[i]) begin
        if (!valid_i[i] && !got_inv) begin
          got_inv = 1'b1;
          inv_idx = IDX_W'(i);
        end
        if (!got_any || rank_i[i] > best) begin
          got_any = 1'b1;
          best    = rank_i[i];
          lru_idx = IDX_W'(i);
        end
      end
    end
    victim_o = got_inv ? inv_idx : lru_idx;
  end

  // R2
  uniq_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) $onehot0(match));
endmodule

// File: rtl/flb_lru.sv
module flb_lru import flb_pkg::*; (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       touch_i,
  input  logic [IDX_W-1:0]           touch_idx_i,
  output logic [NBUF-1:0][IDX_W-1:0] rank_o
);
  logic [NBUF-1:0][IDX_W-1:0] rank_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NBUF; i++) rank_q[i] <= IDX_W'(i);
    end else if (touch_i) begin
      for (int i = 0; i < NBUF; i++) begin
        if (IDX_W'(i) == touch_idx_i)            rank_q[i] <= '0;
        else if (rank_q[i] < rank_q[touch_idx_i]) rank_q[i] <= rank_q[i] + 1'b1;
      end
    end
  end

  assign rank_o = rank_q;

  logic [NBUF-1:0] seen;
  always_comb begin
    seen = '0;
    for (int i = 0; i < NBUF; i++) seen[rank_q[i]] = 1'b1;
  end

  // R5
  rank_perm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) $countones(seen) == NBUF);
endmodule

// File: rtl/flash_line_buf.sv
module flash_line_buf import flb_pkg::*; #(
  parameter int unsigned LINE_AW = 12,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned WS_W    = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  input  logic [LINE_AW-1:0] req_line_i,
  input  logic               req_instr_i,
  input  logic               req_seq_i,
  input  logic               buf_en_i,
  input  logic [1:0]         part_mode_i,
  input  logic               pf_instr_en_i,
  input  logic               pf_data_en_i,
  input  logic [WS_W-1:0]    ws_emul_i,
  input  logic               inv_i,
  output logic               arr_req_o,
  output logic [LINE_AW-1:0] arr_line_o,
  input  logic               arr_ack_i,
  input  logic [DATA_W-1:0]  arr_data_i,
  output logic               busy_o,
  output logic               rsp_valid_o,
  output logic               rsp_hit_o,
  output logic [DATA_W-1:0]  rsp_data_o
);
  fsm_e                        state_q;
  logic [LINE_AW-1:0]          cur_q;
  logic                        instr_q, cach_q, drop_q;
  logic [NBUF-1:0]             valid_q;
  logic [NBUF-1:0][LINE_AW-1:0] tag_q;
  logic [NBUF-1:0][DATA_W-1:0]  data_q;
  logic [NBUF-1:0][IDX_W-1:0]   rank;

  logic               idle, accept, ws_on, inv_now, drop_eff;
  logic               look_instr, hit, pf_hit, hit_ok;
  logic               fill_done, install, go_pf, pf_type_en, touch;
  logic [LINE_AW-1:0] look_line, nxt_line;
  logic [NBUF-1:0]    mask;
  logic [IDX_W-1:0]   hit_idx, victim, touch_idx;

  assign idle       = (state_q == ST_IDLE);
  assign accept     = idle & req_valid_i;
  assign ws_on      = |ws_emul_i;
  assign inv_now    = inv_i | ~buf_en_i | (accept & ~req_seq_i & ws_on);
  assign drop_eff   = drop_q | inv_now;
  assign look_line  = idle ? req_line_i  : cur_q;
  assign look_instr = idle ? req_instr_i : instr_q;
  assign nxt_line   = cur_q + LINE_AW'(1);
  assign mask       = allow_mask(part_mode_i, look_instr);

  flb_lookup #(.LINE_AW(LINE_AW)) u_lookup (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .line_i    (look_line),
    .pf_line_i (nxt_line),
    .mask_i    (mask),
    .valid_i   (valid_q),
    .tags_i    (tag_q),
    .rank_i    (rank),
    .hit_o     (hit),
    .hit_idx_o (hit_idx),
    .pf_hit_o  (pf_hit),
    .victim_o  (victim)
  );

  assign hit_ok     = accept & hit & buf_en_i & ~ws_on;
  assign fill_done  = (state_q == ST_FILL) & arr_ack_i;
  assign pf_type_en = instr_q ? pf_instr_en_i
                              : (pf_data_en_i & (part_mode_i != PM_SPLIT_3I1D));
  assign install    = arr_ack_i & (((state_q == ST_FILL) & cach_q & ~drop_eff) |
                                   ((state_q == ST_PREF) & ~inv_now));
  assign go_pf      = fill_done & cach_q & ~drop_eff & pf_type_en & ~pf_hit;
  assign touch      = hit_ok | install;
  assign touch_idx  = hit_ok ? hit_idx : victim;

  flb_lru u_lru (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .touch_i     (touch),
    .touch_idx_i (touch_idx),
    .rank_o      (rank)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cur_q   <= '0;
      instr_q <= 1'b0;
      cach_q  <= 1'b0;
      drop_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept && !hit_ok) begin
          state_q <= ST_FILL;
          cur_q   <= req_line_i;
          instr_q <= req_instr_i;
          cach_q  <= buf_en_i & ~ws_on;
          drop_q  <= 1'b0;
        end
        ST_FILL: begin
          drop_q <= drop_eff;
          if (arr_ack_i) begin
            state_q <= go_pf ? ST_PREF : ST_IDLE;
            if (go_pf) cur_q <= nxt_line;
          end
        end
        ST_PREF: if (inv_now || arr_ack_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      tag_q   <= '0;
      data_q  <= '0;
    end else begin
      if (install) begin
        tag_q[victim]  <= cur_q;
        data_q[victim] <= arr_data_i;
      end
      for (int i = 0; i < NBUF; i++) begin
        if (inv_now)                                valid_q[i] <= 1'b0;
        else if (install && victim == IDX_W'(i))    valid_q[i] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_hit_o   <= 1'b0;
      rsp_data_o  <= '0;
    end else begin
      rsp_valid_o <= hit_ok | fill_done;
      rsp_hit_o   <= hit_ok;
      rsp_data_o  <= hit_ok ? data_q[hit_idx] : arr_data_i;
    end
  end

  assign busy_o     = ~idle;
  assign arr_req_o  = ~idle;
  assign arr_line_o = cur_q;

  // R7
  inv_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) inv_i |=> (valid_q == '0));
  // R8
  en_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) !buf_en_i |=> (valid_q == '0));
  // R2
  hit_no_fetch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) hit_ok |=> !arr_req_o);
  // R6
  split3_no_data_pf_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PREF) |-> (instr_q || part_mode_i != PM_SPLIT_3I1D));
  // R10
  pf_abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PREF && inv_now) |=> !arr_req_o);
  // R11
  busy_rsp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && !hit_ok) |=> busy_o);
endmodule

// File: tb/flash_line_buf_tb.sv
module flash_line_buf_tb_top;
  localparam int LAW = 12;
  localparam int DW  = 32;
  localparam int WSW = 5;
  localparam int LAT = 3;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic req_valid_i = 0, req_instr_i = 0, req_seq_i = 0;
  logic [LAW-1:0] req_line_i = '0;
  logic buf_en_i = 1, pf_instr_en_i = 1, pf_data_en_i = 1, inv_i = 0;
  logic [1:0] part_mode_i = 2'b00;
  logic [WSW-1:0] ws_emul_i = '0;
  logic arr_ack_i = 0;
  logic [DW-1:0] arr_data_i = '0;
  logic arr_req_o, busy_o, rsp_valid_o, rsp_hit_o;
  logic [LAW-1:0] arr_line_o;
  logic [DW-1:0] rsp_data_o;

  always #2.5 clk_i = ~clk_i;

  flash_line_buf #(.LINE_AW(LAW), .DATA_W(DW), .WS_W(WSW)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .req_line_i(req_line_i),
    .req_instr_i(req_instr_i), .req_seq_i(req_seq_i), .buf_en_i(buf_en_i),
    .part_mode_i(part_mode_i), .pf_instr_en_i(pf_instr_en_i), .pf_data_en_i(pf_data_en_i),
    .ws_emul_i(ws_emul_i), .inv_i(inv_i), .arr_req_o(arr_req_o), .arr_line_o(arr_line_o),
    .arr_ack_i(arr_ack_i), .arr_data_i(arr_data_i), .busy_o(busy_o),
    .rsp_valid_o(rsp_valid_o), .rsp_hit_o(rsp_hit_o), .rsp_data_o(rsp_data_o));

  int n_chk = 0, n_bad = 0;
  string phase = "R1";

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] line_val(input int l);
    return DW'(l * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
  endfunction

  // ---------------- reference model ----------------
  bit          m_valid[4];
  int          m_line[4];
  logic [DW-1:0] m_data[4];
  int          m_ts[4];
  int          tick;
  int          m_state;  // 0 idle, 1 demand fill, 2 lookahead fill
  int          m_cur;
  bit          m_instr, m_cach, m_drop;
  bit          e_rv, e_hit;
  logic [DW-1:0] e_data;

  function automatic bit may_use(input int b, input int mode, input bit instr);
    if (mode == 1) return instr ? (b < 2) : (b >= 2);
    if (mode == 2) return instr ? (b < 3) : (b == 3);
    return 1'b1;
  endfunction

  function automatic int find(input int l, input bit instr);
    for (int b = 0; b < 4; b++)
      if (m_valid[b] && m_line[b] == l && may_use(b, part_mode_i, instr)) return b;
    return -1;
  endfunction

  function automatic int pick(input bit instr);
    int best = -1;
    for (int b = 0; b < 4; b++)
      if (may_use(b, part_mode_i, instr) && !m_valid[b]) return b;
    for (int b = 0; b < 4; b++)
      if (may_use(b, part_mode_i, instr) && (best < 0 || m_ts[b] < m_ts[best])) best = b;
    return best;
  endfunction

  task automatic use_buf(input int b);
    tick++;
    m_ts[b] = tick;
  endtask

  task automatic store(input bit instr);
    int v = pick(instr);
    m_valid[v] = 1; m_line[v] = m_cur; m_data[v] = arr_data_i;
    use_buf(v);
  endtask

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int b = 0; b < 4; b++) begin m_valid[b] = 0; m_ts[b] = -b; end
      tick = 0; m_state = 0; m_cur = 0; e_rv = 0; e_hit = 0;
    end else begin
      bit acc, ws_on, inv_now, de, pfe;
      int h, nl;
      acc     = (m_state == 0) && req_valid_i;
      ws_on   = (ws_emul_i != 0);
      inv_now = inv_i || !buf_en_i || (acc && !req_seq_i && ws_on);
      e_rv = 0; e_hit = 0;
      case (m_state)
        0: if (acc) begin
          h = (buf_en_i && !ws_on) ? find(int'(req_line_i), req_instr_i) : -1;
          if (h >= 0) begin
            e_rv = 1; e_hit = 1; e_data = m_data[h]; use_buf(h);
          end else begin
            m_state = 1; m_cur = int'(req_line_i); m_instr = req_instr_i;
            m_cach = buf_en_i && !ws_on; m_drop = 0;
          end
        end
        1: begin
          de = m_drop || inv_now;
          m_drop = de;
          if (arr_ack_i) begin
            e_rv = 1; e_data = arr_data_i;
            nl  = (m_cur + 1) % (1 << LAW);
            pfe = m_instr ? pf_instr_en_i : (pf_data_en_i && part_mode_i != 2);
            pfe = pfe && m_cach && !de && find(nl, m_instr) < 0;
            if (m_cach && !de) store(m_instr);
            if (pfe) begin m_state = 2; m_cur = nl; end
            else m_state = 0;
          end
        end
        default: begin
          if (inv_now) m_state = 0;
          else if (arr_ack_i) begin store(m_instr); m_state = 0; end
        end
      endcase
      if (inv_now) for (int b = 0; b < 4; b++) m_valid[b] = 0;
    end
  end

  // ---------------- per-cycle comparison ----------------
  always @(negedge clk_i) begin
    if (rst_ni) begin
      chk(busy_o == (m_state != 0), phase, "busy_o R11", busy_o, m_state != 0);
      chk(arr_req_o == (m_state != 0), phase, "arr_req_o R3", arr_req_o, m_state != 0);
      if (m_state != 0) chk(arr_line_o == LAW'(m_cur), phase, "arr_line_o R6", arr_line_o, m_cur);
      chk(rsp_valid_o == e_rv, phase, "rsp_valid_o R3", rsp_valid_o, e_rv);
      if (e_rv) begin
        chk(rsp_hit_o == e_hit, phase, "rsp_hit_o R2", rsp_hit_o, e_hit);
        chk(rsp_data_o == e_data, phase, "rsp_data_o R2", rsp_data_o, e_data);
      end
    end
  end

  // ---------------- array model ----------------
  int acnt = 0;
  always @(negedge clk_i) begin
    if (!arr_req_o || arr_ack_i) begin
      arr_ack_i <= 1'b0;
      acnt = 0;
    end else begin
      acnt++;
      if (acnt >= LAT) begin
        arr_ack_i  <= 1'b1;
        arr_data_i <= line_val(int'(arr_line_o));
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic issue(input int l, input bit instr, input bit seq);
    do @(negedge clk_i); while (busy_o);
    req_valid_i = 1; req_line_i = LAW'(l); req_instr_i = instr; req_seq_i = seq;
    @(negedge clk_i);
    req_valid_i = 0;
  endtask

  task automatic expect_hit(input int l, input bit instr, input bit seq, input bit exp, input string req);
    issue(l, instr, seq);
    chk(rsp_valid_o == exp && rsp_hit_o == exp, req, "direct hit", {rsp_valid_o, rsp_hit_o}, {exp, exp});
  endtask

  task automatic wait_idle();
    do @(negedge clk_i); while (busy_o);
    @(negedge clk_i);
  endtask

  task automatic set_cfg(input logic [1:0] mode, input bit pfi, input bit pfd);
    @(negedge clk_i); buf_en_i = 0;
    @(negedge clk_i); part_mode_i = mode; pf_instr_en_i = pfi; pf_data_en_i = pfd;
    @(negedge clk_i); buf_en_i = 1;
  endtask

  task automatic pulse_inv();
    inv_i = 1; @(negedge clk_i); inv_i = 0;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    phase = "R1";
    repeat (3) @(negedge clk_i);
    chk(!busy_o && !arr_req_o && !rsp_valid_o, "R1", "reset outputs",
        {busy_o, arr_req_o, rsp_valid_o}, 0);
    rst_ni = 1;
    @(negedge clk_i);
    chk(!busy_o && !rsp_valid_o, "R1", "after reset", {busy_o, rsp_valid_o}, 0);

    phase = "R3 R6";
    expect_hit(5, 1, 0, 0, "R3");
    wait_idle();
    phase = "R2 R4";
    expect_hit(5, 1, 1, 1, "R2");
    expect_hit(6, 1, 1, 1, "R6");
    expect_hit(6, 0, 1, 1, "R4");
    phase = "R6 wrap";
    expect_hit(12'hFFF, 0, 0, 0, "R6");
    wait_idle();
    expect_hit(0, 0, 1, 1, "R6");

    phase = "R5";
    set_cfg(2'b00, 0, 0);
    for (int i = 10; i < 14; i++) begin issue(i, 1, 0); wait_idle(); end
    expect_hit(10, 1, 1, 1, "R5");
    issue(14, 1, 0); wait_idle();
    expect_hit(10, 1, 1, 1, "R5");
    expect_hit(11, 1, 1, 0, "R5");
    wait_idle();
    expect_hit(13, 1, 1, 1, "R5");

    phase = "R7";
    pulse_inv();
    expect_hit(13, 1, 1, 0, "R7");
    wait_idle();

    phase = "R8";
    buf_en_i = 0;
    expect_hit(20, 0, 1, 0, "R8"); wait_idle();
    expect_hit(20, 0, 1, 0, "R8"); wait_idle();
    buf_en_i = 1;
    expect_hit(20, 0, 1, 0, "R8"); wait_idle();
    expect_hit(20, 0, 1, 1, "R8");

    phase = "R9";
    ws_emul_i = 3;
    expect_hit(20, 0, 1, 0, "R9"); wait_idle();
    ws_emul_i = 0;
    expect_hit(20, 0, 1, 1, "R9");
    ws_emul_i = 3;
    expect_hit(20, 0, 0, 0, "R9"); wait_idle();
    ws_emul_i = 0;
    expect_hit(20, 0, 1, 0, "R9"); wait_idle();

    phase = "R4 split2";
    set_cfg(2'b01, 0, 0);
    issue(30, 1, 0); wait_idle();
    expect_hit(30, 0, 1, 0, "R4"); wait_idle();
    expect_hit(30, 1, 1, 1, "R4");
    expect_hit(30, 0, 1, 1, "R4");

    phase = "R6 split3";
    set_cfg(2'b10, 1, 1);
    issue(40, 0, 0); wait_idle();
    expect_hit(41, 0, 1, 0, "R6"); wait_idle();
    issue(40, 1, 0); wait_idle();
    expect_hit(41, 1, 1, 1, "R6");

    phase = "R10";
    set_cfg(2'b00, 1, 1);
    issue(50, 1, 0);
    pulse_inv();
    wait_idle();
    expect_hit(50, 1, 1, 0, "R10"); wait_idle();
    expect_hit(51, 1, 1, 1, "R6");
    pulse_inv();
    issue(60, 1, 0);
    while (!(arr_req_o && arr_line_o == LAW'(61))) @(negedge clk_i);
    pulse_inv();
    chk(!arr_req_o, "R10", "lookahead abort", arr_req_o, 0);
    wait_idle();
    expect_hit(61, 1, 1, 0, "R10"); wait_idle();

    phase = "R11";
    set_cfg(2'b00, 0, 0);
    issue(70, 0, 0);
    req_valid_i = 1; req_line_i = LAW'(90); req_instr_i = 0; req_seq_i = 1;
    @(negedge clk_i); @(negedge clk_i);
    req_valid_i = 0;
    wait_idle();
    expect_hit(90, 0, 1, 0, "R11"); wait_idle();

    phase = "R2-random R4 R5 R6 R7 R9 R10";
    for (int it = 0; it < 4000; it++) begin
      int r = $urandom % 100;
      if (r < 2) set_cfg(2'($urandom % 4), 1'($urandom % 2), 1'($urandom % 2));
      ws_emul_i = ($urandom % 8 == 0) ? WSW'($urandom % 32) : '0;
      issue($urandom % 16, 1'($urandom % 2), 1'($urandom % 4 != 0));
      if (r >= 90) pulse_inv();
    end
    ws_emul_i = 0;
    wait_idle();
    finish_run();
  end
endmodule